// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a few raw reset causes into one clean, timed system reset. It watches a digitised "supply below threshold" flag from an external comparator, two board-level reset pins that double as manual reset inputs, and a timeout pulse from an on-chip watchdog. From these it drives two open-drain reset pins of opposite polarity, plus a level that tells the memory controller to refuse every access.

A low supply holds reset for as long as it lasts. Short dips are filtered out by requiring a run of consecutive low-supply samples. When the supply recovers, reset is stretched for a fixed number of clock cycles. The same fixed stretch also follows three other causes: the active edge on either manual pin, a watchdog trip, and the release of the block's own synchronous reset.

A manual pin held active for longer than the stretch does not lengthen the pulse. However, the memory-blocking level stays high while any pin still reads back as active. Each pin is modelled as a drive enable plus a readback of the pin level. The block ignores the pin edges that its own drive causes.

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst_n` is low, both drive enables and `mem_block_o` are 1. After `rst_n` is released following clock edge c, the drives are released after edge c+TIMEOUT_CYC.
- R2: When `vlow_i` is 1 for GLITCH_CYC consecutive samples, both drives assert. If `vlow_i` rises after edge c, the drives are 1 from edge c+SYNC_STAGES+GLITCH_CYC onward.
- R3: A `vlow_i` pulse shorter than GLITCH_CYC samples leaves both drives at 0.
- R4: Both drives stay at 1 for as long as the filtered supply-low condition lasts, whatever its length.
- R5: If `vlow_i` falls after edge c, the drives are released after edge c+SYNC_STAGES+1+TIMEOUT_CYC.
- R6: A falling edge on `rstn_pin_i` (pin level 0 = active) that follows edge c starts a timed reset. That reset is released after edge c+SYNC_STAGES+1+TIMEOUT_CYC.
- R7: A rising edge on `rst_pin_i` (pin level 1 = active) that follows edge c starts the same timed reset, with the same release cycle as R6.
- R8: A manual pin held active past the timeout does not extend the drives; they release on schedule. The later return of the pin to its inactive level starts no reset.
- R9: `mem_block_o` is 1 while the drives are active or while either pin reads back active. It falls SYNC_STAGES cycles after the last of these ends.
- R10: A one-cycle `wdt_trip_i` pulse after edge c starts a timed reset that is released after edge c+1+TIMEOUT_CYC.
- R11: Pin edges caused by the block's own drive never restart the timer, so every timed reset lasts exactly its scheduled length.
- R12: `rstn_drv_o` and `rst_drv_o` are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| vlow_i | input | 1 | Comparator flag, 1 = supply below threshold (asynchronous) |
| wdt_trip_i | input | 1 | One-cycle watchdog timeout pulse, synchronous to clk |
| rstn_pin_i | input | 1 | Readback of the active-low reset pin level |
| rst_pin_i | input | 1 | Readback of the active-high reset pin level |
| rstn_drv_o | output | 1 | 1 = pull the active-low pin down |
| rst_drv_o | output | 1 | 1 = pull the active-high pin up |
| mem_block_o | output | 1 | 1 = memory access must be refused |

## Verification
Each stimulus has a fixed latency to its result:
- Asynchronous inputs cross SYNC_STAGES flops before any logic sees them. A supply-low assertion therefore appears SYNC_STAGES+GLITCH_CYC cycles after the flag rises.
- A release appears SYNC_STAGES+1+TIMEOUT_CYC cycles after a supply recovery or manual edge, and 1+TIMEOUT_CYC cycles after a watchdog pulse.
- The memory block trails the pin readback by SYNC_STAGES cycles.

The driver computes each release cycle from these formulas and queues it. A monitor timestamps every falling drive edge against a free-running cycle counter and compares it with the queue, so an early, late or extra release is caught exactly. Level checks sample at the computed cycle and at the cycle just before it.

// File: rtl/supv_pkg.sv
// Package: shared helpers for the reset sequencer.
// Assumes: counts passed to cnt_width are at least 1.
package supv_pkg;

    // Width of a counter that must hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

    // Pin polarity selector for the manual reset edge detectors.
    typedef enum logic {
        PIN_ACT_HIGH = 1'b0,
        PIN_ACT_LOW  = 1'b1
    } pin_pol_e;

endpackage

// File: rtl/supv_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes: STAGES >= 1; RST_VAL is the inactive level of the signal.
module supv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supv_glitch_filter.sv
// Module: declares the supply low only after GLITCH_CYC consecutive
// synchronised low-supply samples; clears at the first good sample.
// Assumes: smp_i is already synchronous to clk; GLITCH_CYC >= 1.
module supv_glitch_filter
    import supv_pkg::*;
#(
    parameter int GLITCH_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    output logic low_o
);
    localparam int RW = cnt_width(GLITCH_CYC);
    localparam logic [RW-1:0] RUN_LAST = RW'(GLITCH_CYC - 1);

    logic [RW-1:0] run_q;
    logic          low_q;

    // Count the low-supply run and set the filtered flag at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            low_q <= 1'b0;
        end else if (!smp_i) begin
            run_q <= '0;
            low_q <= 1'b0;
        end else if (run_q == RUN_LAST) begin
            low_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign low_o = low_q;

    // The filtered flag only rises on a sample that is itself low-supply.
    assert_rise_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_q) |-> $past(smp_i));

    // A good sample always clears the filtered flag on the next edge.
    assert_clear_on_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_i |=> !low_q);
endmodule

// File: rtl/supv_edge_det.sv
// Module: detects the active edge of one synchronised manual reset pin,
// ignoring edges while the block drives the pins or just after.
// Assumes: pin_i is synchronous; MASK_LEN covers the readback latency.
module supv_edge_det
    import supv_pkg::*;
#(
    parameter pin_pol_e POL      = PIN_ACT_LOW,
    parameter int       MASK_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic drive_i,
    output logic trig_o
);
    localparam logic IDLE_LVL = (POL == PIN_ACT_LOW) ? 1'b1 : 1'b0;

    logic                prev_q;
    logic [MASK_LEN-1:0] hist_q;
    logic                raw_edge;
    logic                masked;

    // Remember last pin level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= pin_i;
    end

    // Keep a short history of our own drive to hide its echo.
    generate
        if (MASK_LEN == 1) begin : g_h1
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '1;
                else        hist_q <= drive_i;
            end
        end else begin : g_hn
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '1;
                else        hist_q <= {hist_q[MASK_LEN-2:0], drive_i};
            end
        end
    endgenerate

    // Select which transition counts as the active edge.
    generate
        if (POL == PIN_ACT_LOW) begin : g_fall
            assign raw_edge = prev_q & ~pin_i;
        end else begin : g_rise
            assign raw_edge = ~prev_q & pin_i;
        end
    endgenerate

    assign masked = drive_i | (|hist_q);
    assign trig_o = raw_edge & ~masked;

    // A trigger never comes while the block itself drives the pins.
    assert_no_self_trigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !drive_i);

    // A trigger always follows a pin that was idle on the previous cycle.
    assert_trig_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (prev_q == IDLE_LVL));
endmodule

// File: rtl/supv_stretch_timer.sv
// Module: reset stretch timer; held full while the supply is low,
// reloaded by any start request, counts down to release otherwise.
// Assumes: start_i is a single-cycle request; TIMEOUT_CYC >= 1.
module supv_stretch_timer
    import supv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic start_i,
    output logic act_o
);
    localparam int TW = cnt_width(TIMEOUT_CYC);
    localparam logic [TW-1:0] FULL = TW'(TIMEOUT_CYC);

    logic [TW-1:0] remain_q;

    // Load on reset, hold or start; otherwise run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 remain_q <= FULL;
        else if (hold_i || start_i) remain_q <= FULL;
        else if (remain_q != '0)    remain_q <= remain_q - 1'b1;
    end

    assign act_o = hold_i | (remain_q != '0);

    // A start request always makes reset active on the next cycle.
    assert_start_activates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> act_o);

    // The supply recovering never releases reset in the same cycle.
    assert_recovery_stretches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_i) |-> act_o);

    // Release happens only with the supply good in this and the last cycle.
    assert_release_when_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_o) |-> (!hold_i && !$past(hold_i)));
endmodule

// File: rtl/supv_reset_seq.sv
// Module: top of the supply supervisor reset sequencer.
// Combines the filtered supply flag, manual pin edges and watchdog
// pulses into one stretched reset, drives both open-drain pins, and
// blocks memory while any reset source or pin is active.
// Assumes: wdt_trip_i is synchronous; other inputs are asynchronous.
module supv_reset_seq
    import supv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20_000_000,
    parameter int GLITCH_CYC  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_i,
    input  logic wdt_trip_i,
    input  logic rstn_pin_i,
    input  logic rst_pin_i,
    output logic rstn_drv_o,
    output logic rst_drv_o,
    output logic mem_block_o
);
    localparam int MASK_LEN = SYNC_STAGES + 1;

    logic vlow_s;
    logic pin_n_s;
    logic pin_p_s;
    logic supply_low;
    logic trig_n;
    logic trig_p;
    logic start_req;
    logic rst_act;

    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_vlow (
        .clk(clk), .rst_n(rst_n), .d_i(vlow_i), .q_o(vlow_s));

    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin_n (
        .clk(clk), .rst_n(rst_n), .d_i(rstn_pin_i), .q_o(pin_n_s));

    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin_p (
        .clk(clk), .rst_n(rst_n), .d_i(rst_pin_i), .q_o(pin_p_s));

    supv_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk(clk), .rst_n(rst_n), .smp_i(vlow_s), .low_o(supply_low));

    supv_edge_det #(.POL(PIN_ACT_LOW), .MASK_LEN(MASK_LEN)) u_edge_n (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_n_s), .drive_i(rst_act),
        .trig_o(trig_n));

    supv_edge_det #(.POL(PIN_ACT_HIGH), .MASK_LEN(MASK_LEN)) u_edge_p (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_p_s), .drive_i(rst_act),
        .trig_o(trig_p));

    // Any manual edge or watchdog trip requests a timed reset.
    assign start_req = trig_n | trig_p | wdt_trip_i;

    supv_stretch_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .hold_i(supply_low), .start_i(start_req),
        .act_o(rst_act));

    // Both pins share one drive decision; memory also sees pin holds.
    assign rstn_drv_o  = rst_act;
    assign rst_drv_o   = rst_act;
    assign mem_block_o = rst_act | ~pin_n_s | pin_p_s;

    // A watchdog trip is always followed by active pin drive.
    assert_wdt_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_trip_i |=> (rstn_drv_o && rst_drv_o));

    // The memory block never drops while the filtered supply is low.
    assert_block_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> mem_block_o);
endmodule

// File: tb/tb_supv_reset_seq.sv
module tb_supv_reset_seq;
    localparam int T = 50;
    localparam int G = 4;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vlow = 1'b0;
    logic wdt = 1'b0;
    logic ext_n = 1'b0;
    logic ext_p = 1'b0;
    logic rstn_drv, rst_drv, mem_block;
    logic rstn_pin, rst_pin;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int mism = 0;
    bit done = 1'b0;
    logic prev_drv = 1'b0;

    int    due_q[$];
    string tag_q[$];

    assign rstn_pin = ~(rstn_drv | ext_n);
    assign rst_pin  = rst_drv | ext_p;

    supv_reset_seq #(.TIMEOUT_CYC(T), .GLITCH_CYC(G), .SYNC_STAGES(S)) dut (
        .clk(clk), .rst_n(rst_n), .vlow_i(vlow), .wdt_trip_i(wdt),
        .rstn_pin_i(rstn_pin), .rst_pin_i(rst_pin),
        .rstn_drv_o(rstn_drv), .rst_drv_o(rst_drv), .mem_block_o(mem_block));

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_release(input int due, input string tag);
        due_q.push_back(due);
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        check(mism == 0, "R12", mism, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: timestamps each drive release and pops the scoreboard.
    always @(negedge clk) begin
        if (rstn_drv !== rst_drv) mism++;
        if (prev_drv && !rstn_drv) begin
            if (due_q.size() == 0) begin
                check(1'b0, "R11 unexpected release", cyc, -1);
            end else begin
                automatic int    d = due_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cyc == d, t, cyc, d);
            end
        end
        prev_drv = rstn_drv;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int c;
        step(3);
        // R1: reset state
        check(rstn_drv && rst_drv, "R1 drives in reset", int'(rstn_drv), 1);
        check(mem_block == 1'b1, "R1 mem block in reset", int'(mem_block), 1);
        c = cyc; rst_n = 1'b1;
        expect_release(c + T, "R1 power-on release");
        step(T + 10);
        check(due_q.size() == 0, "R1 release seen", due_q.size(), 0);
        check(mem_block == 1'b0, "R9 idle mem block", int'(mem_block), 0);

        // R3: a dip of G-1 samples is filtered
        vlow = 1'b1; step(G - 1); vlow = 1'b0;
        step(12);
        check(rstn_drv == 1'b0, "R3 glitch ignored", int'(rstn_drv), 0);

        // R2: assertion latency of a real supply-low
        c = cyc; vlow = 1'b1;
        wait_cyc(c + S + G - 1);
        check(rstn_drv == 1'b0, "R2 not yet", int'(rstn_drv), 0);
        wait_cyc(c + S + G);
        check(rstn_drv == 1'b1, "R2 asserted", int'(rstn_drv), 1);

        // R4: held for longer than the timeout
        step(3 * T);
        check(rstn_drv && rst_drv, "R4 still held", int'(rstn_drv), 1);

        // R5: release after recovery
        c = cyc; vlow = 1'b0;
        expect_release(c + S + 1 + T, "R5 recovery release");
        step(T + 10);
        check(due_q.size() == 0, "R5 release seen", due_q.size(), 0);

        // R6: short active-low press, plus mem block tail
        c = cyc; ext_n = 1'b1;
        expect_release(c + S + 1 + T, "R6 low-pin edge release");
        step(5); ext_n = 1'b0;
        wait_cyc(c + S + 1 + T + S - 1);
        check(mem_block == 1'b1, "R9 block tail", int'(mem_block), 1);
        wait_cyc(c + S + 1 + T + S);
        check(mem_block == 1'b0, "R9 block end", int'(mem_block), 0);
        step(10);

        // R7: active-high pin rising edge
        c = cyc; ext_p = 1'b1;
        expect_release(c + S + 1 + T, "R7 high-pin edge release");
        step(4); ext_p = 1'b0;
        step(T + 10);
        check(due_q.size() == 0, "R7 release seen", due_q.size(), 0);

        // R8: long hold does not stretch; memory stays blocked
        c = cyc; ext_n = 1'b1;
        expect_release(c + S + 1 + T, "R8 long hold release");
        step(2 * T);
        check(rstn_drv == 1'b0, "R8 drives released under hold", int'(rstn_drv), 0);
        check(mem_block == 1'b1, "R9 block under hold", int'(mem_block), 1);
        c = cyc; ext_n = 1'b0;
        wait_cyc(c + S - 1);
        check(mem_block == 1'b1, "R9 hold tail", int'(mem_block), 1);
        wait_cyc(c + S);
        check(mem_block == 1'b0, "R9 hold end", int'(mem_block), 0);
        step(10);
        check(rstn_drv == 1'b0, "R8 inactive edge ignored", int'(rstn_drv), 0);

        // R10 / R11: watchdog pulse, exact length despite pin echo
        c = cyc; wdt = 1'b1; step(1); wdt = 1'b0;
        expect_release(c + 1 + T, "R10 R11 watchdog release");
        step(T + 10);
        check(due_q.size() == 0, "R10 release seen", due_q.size(), 0);
        check(rstn_drv == 1'b0, "R11 no retrigger", int'(rstn_drv), 0);

        done = 1'b1;
        finish_run();
    end
endmodule